// File: doc/BRIEF.md
# Eight-Line Fixed-Priority Interrupt Controller

This block collects eight device request lines and forwards at most one request to a CPU on a single request output. Each line has a bit in an 8-bit mask register. Of the lines that are pending, unmasked and allowed, line 0 wins and line 7 loses. When the CPU acknowledges, the block moves the winning line into an in-service set. On the next cycle it presents the type number, which is 08H plus the line number, on its vector output.

A line that is in service blocks every line of equal or lower priority. Only a strictly higher line can nest above it. Software releases the highest in-service line by writing the end-of-interrupt code 20H to the command port (address 0). The mask port is at address 1 and can be written and read back.

The sequencing is a three-state machine:
- **ST_IDLE** goes to **ST_RAISE** when an eligible request exists.
- **ST_RAISE** drives the request output. It goes back to **ST_IDLE** if no eligible request remains. It goes to **ST_VECTOR** when acknowledged.
- **ST_VECTOR** presents the vector for one cycle and always returns to **ST_IDLE**.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, int_req and vec_valid are 0, the mask reads 00H (every line enabled) and no line is pending or in service.
- R2: A rising edge on an unmasked line, with nothing in service, is latched as pending. int_req is 1 at the second rising clock edge after the edge is first sampled.
- R3: When several eligible lines are pending, the lowest-numbered line wins.
- R4: An acknowledge while int_req is 1 causes the following things:
  - vec_valid is 1 for exactly one cycle after the acknowledge edge.
  - vec_out is then 08H plus the winning line number.
  - int_req drops for that cycle.
- R5: A write with bus_addr = 1 loads the mask, and bit n controls line n. A 1 blocks the line and a 0 enables it. bus_rdata returns the mask when bus_addr = 1 and 00H when bus_addr = 0.
- R6: An edge on a masked line stays pending and is forwarded once its mask bit is cleared.
- R7: While any line is in service, int_req is raised only for lines numbered strictly lower than the lowest-numbered in-service line.
- R8: A write of 20H with bus_addr = 0 clears the lowest-numbered in-service line. Held requests are then forwarded. Any other value written with bus_addr = 0 has no effect.
- R9: Only rising edges create requests. A line held high after being serviced raises no further request.
- R10: An acknowledge while int_req is 0 is ignored and produces no vector.
- R11: If the request seen in ST_RAISE becomes ineligible (for example it is masked), the block returns to ST_IDLE and int_req drops one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 8 | Device request lines, bit n is line n |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | Port select: 0 command, 1 mask |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected port |
| int_req | output | 1 | Interrupt request to the CPU |
| int_ack | input | 1 | Acknowledge from the CPU |
| vec_out | output | 8 | Interrupt type number |
| vec_valid | output | 1 | vec_out is valid this cycle |

## Verification
The result timings are as follows:
- A new line edge raises int_req two rising edges after it is driven: one edge to latch it and one to enter ST_RAISE.
- The vector is valid in the cycle after the acknowledge edge.
- A mask or end-of-interrupt write changes int_req one edge after the write edge.
- Read data on bus_rdata is combinational.

The bench drives inputs on falling edges and samples on falling edges at those counts. "Stays low" checks wait three or more cycles so that a late request would be seen. Each table row starts from reset, so a pending line cannot leak into the next row.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    // Sequencer states for the request/acknowledge handshake
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RAISE  = 2'd1,
        ST_VECTOR = 2'd2
    } ctl_state_t;

    localparam int unsigned LINES_DEF  = 8;
    localparam int unsigned DATA_W_DEF = 8;

endpackage

// File: rtl/irqc_req_latch.sv
module irqc_req_latch #(
    parameter int unsigned N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lines,
    input  logic [N-1:0] clr,
    output logic [N-1:0] pend
);
    logic [N-1:0] prev_q;
    logic [N-1:0] pend_q;
    logic [N-1:0] rise;

    assign rise = lines & ~prev_q;
    assign pend = pend_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            pend_q <= '0;
        end else begin
            prev_q <= lines;
            pend_q <= (pend_q & ~clr) | rise;
        end
    end

    // Every detected edge is pending one cycle later
    assert_edge_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|rise) |=> (($past(rise) & ~pend_q) == '0));

endmodule

// File: rtl/irqc_resolver.sv
module irqc_resolver #(
    parameter int unsigned N     = 8,
    parameter int unsigned IDX_W = 3
) (
    input  logic [N-1:0]     pend,
    input  logic [N-1:0]     mask,
    input  logic [N-1:0]     svc,
    output logic [N-1:0]     win_onehot,
    output logic [IDX_W-1:0] win_idx,
    output logic             win_any,
    output logic [N-1:0]     svc_top
);
    localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

    logic [N-1:0] allow;
    logic [N-1:0] elig;

    // A line may interrupt only if no line of equal or higher rank is in service
    for (genvar g = 0; g < N; g++) begin : g_allow
        assign allow[g] = ~|svc[g:0];
    end

    assign elig       = pend & ~mask & allow;
    assign win_any    = |elig;
    assign win_onehot = elig & (~elig + ONE);
    assign svc_top    = svc & (~svc + ONE);

    always_comb begin
        win_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (elig[i]) win_idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/irqc_regs.sv
module irqc_regs #(
    parameter int unsigned             DATA_W   = 8,
    parameter logic [DATA_W-1:0]       EOI_CODE = 8'h20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              addr_sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] mask,
    output logic              eoi_pulse,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mask_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (wr_en && addr_sel) begin
            mask_q <= wdata;
        end
    end

    assign mask      = mask_q;
    assign eoi_pulse = wr_en && !addr_sel && (wdata == EOI_CODE);
    assign rdata     = addr_sel ? mask_q : '0;

    // Mask changes only on a mask-port write
    assert_mask_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr_sel) |=> $stable(mask_q));

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
    parameter int unsigned       NUM_LINES = 8,
    parameter int unsigned       DATA_W    = 8,
    parameter logic [DATA_W-1:0] VEC_BASE  = 8'h08,
    parameter logic [DATA_W-1:0] EOI_CODE  = 8'h20
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic                 bus_wr,
    input  logic                 bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic                 int_req,
    input  logic                 int_ack,
    output logic [DATA_W-1:0]    vec_out,
    output logic                 vec_valid
);
    import irqc_pkg::*;

    localparam int unsigned        IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
    localparam logic [NUM_LINES-1:0] ONE = {{(NUM_LINES-1){1'b0}}, 1'b1};

    ctl_state_t state_q, state_d;

    logic [NUM_LINES-1:0] pend, mask_w, svc_q, svc_top, win_onehot, grant;
    logic [IDX_W-1:0]     win_idx;
    logic                 win_any, eoi_pulse;
    logic [DATA_W-1:0]    vec_q, mask_full;

    irqc_regs #(.DATA_W(DATA_W), .EOI_CODE(EOI_CODE)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_wr),
        .addr_sel (bus_addr),
        .wdata    (bus_wdata),
        .mask     (mask_full),
        .eoi_pulse(eoi_pulse),
        .rdata    (bus_rdata)
    );

    assign mask_w = mask_full[NUM_LINES-1:0];

    irqc_req_latch #(.N(NUM_LINES)) u_latch (
        .clk  (clk),
        .rst_n(rst_n),
        .lines(irq_in),
        .clr  (grant),
        .pend (pend)
    );

    irqc_resolver #(.N(NUM_LINES), .IDX_W(IDX_W)) u_resolve (
        .pend      (pend),
        .mask      (mask_w),
        .svc       (svc_q),
        .win_onehot(win_onehot),
        .win_idx   (win_idx),
        .win_any   (win_any),
        .svc_top   (svc_top)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (win_any) state_d = ST_RAISE;
            ST_RAISE: begin
                if (!win_any)     state_d = ST_IDLE;
                else if (int_ack) state_d = ST_VECTOR;
            end
            ST_VECTOR: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        int_req   = 1'b0;
        vec_valid = 1'b0;
        grant     = '0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_RAISE: begin
                int_req = 1'b1;
                if (int_ack) grant = win_onehot;
            end
            ST_VECTOR: vec_valid = 1'b1;
            default:   ;
        endcase
    end

    // In-service set and vector capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            svc_q <= '0;
            vec_q <= '0;
        end else begin
            svc_q <= (svc_q & ~(eoi_pulse ? svc_top : '0)) | grant;
            if (|grant) vec_q <= VEC_BASE + DATA_W'(win_idx);
        end
    end

    assign vec_out = vec_q;

    assert_vec_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |=> !vec_valid);

    assert_vec_after_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> $past(int_req && int_ack));

    // Granted line ranks above everything already in service
    assert_nested_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|grant) |-> ((svc_q & (grant - ONE)) == '0));

    assert_eoi_retires_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_pulse && (|svc_q) && !(|grant)) |=>
            ($countones(svc_q) + 1 == $countones($past(svc_q))));

    assert_req_has_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
        int_req |-> $past(win_any));

endmodule

// File: tb/irq_prio_ctrl_test.sv
`timescale 1ns/1ps
module irq_prio_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_in = '0;
    logic       bus_wr = 1'b0;
    logic       bus_addr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       int_req;
    logic       int_ack = 1'b0;
    logic [7:0] vec_out;
    logic       vec_valid;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    irq_prio_ctrl uut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .int_req(int_req), .int_ack(int_ack),
        .vec_out(vec_out), .vec_valid(vec_valid)
    );

    // {expect_req, mask, lines, expect_vector}
    localparam logic [24:0] VEC_TABLE [8] = '{
        {1'b1, 8'h00, 8'h01, 8'h08},
        {1'b1, 8'h00, 8'h80, 8'h0F},
        {1'b1, 8'h00, 8'hA4, 8'h0A},
        {1'b1, 8'hFE, 8'hFF, 8'h08},
        {1'b1, 8'h01, 8'h03, 8'h09},
        {1'b0, 8'hFF, 8'h10, 8'h00},
        {1'b1, 8'h0F, 8'h30, 8'h0C},
        {1'b1, 8'h00, 8'h60, 8'h0D}
    };

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; irq_in = '0; bus_wr = 1'b0; int_ack = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic wr_reg(input logic a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic ack_expect(input string tag, input logic [7:0] exp_vec);
        int_ack = 1'b1;
        tick();
        int_ack = 1'b0;
        chk({tag, " vec_valid"}, {7'd0, vec_valid}, 8'h01);
        chk({tag, " vector"}, vec_out, exp_vec);
        chk({tag, " int_req low"}, {7'd0, int_req}, 8'h00);
    endtask

    initial begin
        // R1 reset state
        do_reset();
        chk("R1 int_req", {7'd0, int_req}, 8'h00);
        chk("R1 vec_valid", {7'd0, vec_valid}, 8'h00);
        bus_addr = 1'b1; #1;
        chk("R1 mask", bus_rdata, 8'h00);

        // R5 readback on both ports
        tick();
        wr_reg(1'b1, 8'h5A);
        bus_addr = 1'b1; #1;
        chk("R5 mask readback", bus_rdata, 8'h5A);
        bus_addr = 1'b0; #1;
        chk("R5 command read", bus_rdata, 8'h00);

        // Table: R2 R3 R4 R5
        for (int k = 0; k < 8; k++) begin
            logic [24:0] row;
            row = VEC_TABLE[k];
            do_reset();
            wr_reg(1'b1, row[23:16]);
            irq_in = row[15:8];
            tick(); tick();
            chk($sformatf("R2 R5 row%0d int_req", k), {7'd0, int_req}, {7'd0, row[24]});
            if (row[24]) ack_expect($sformatf("R3 R4 row%0d", k), row[7:0]);
            irq_in = '0;
        end

        // R10 acknowledge with nothing requested
        do_reset();
        int_ack = 1'b1; tick(); int_ack = 1'b0;
        chk("R10 vec_valid", {7'd0, vec_valid}, 8'h00);
        chk("R10 int_req", {7'd0, int_req}, 8'h00);

        // R11 request withdrawn by masking, then R6 forwarded on unmask
        do_reset();
        irq_in = 8'h04;
        tick(); tick();
        chk("R11 raised", {7'd0, int_req}, 8'h01);
        wr_reg(1'b1, 8'h04);
        tick();
        chk("R11 withdrawn", {7'd0, int_req}, 8'h00);
        repeat (2) tick();
        chk("R6 held while masked", {7'd0, int_req}, 8'h00);
        wr_reg(1'b1, 8'h00);
        tick();
        chk("R6 forwarded", {7'd0, int_req}, 8'h01);
        ack_expect("R6", 8'h0A);

        // Nesting and end-of-interrupt: R7 R8 R9
        do_reset();
        irq_in = 8'h08;
        tick(); tick();
        chk("R7 line3 req", {7'd0, int_req}, 8'h01);
        ack_expect("R7 line3", 8'h0B);
        irq_in = 8'h28;
        repeat (3) tick();
        chk("R7 lower held", {7'd0, int_req}, 8'h00);
        irq_in = 8'h20; tick(); irq_in = 8'h28;
        repeat (3) tick();
        chk("R7 equal held", {7'd0, int_req}, 8'h00);
        irq_in = 8'h2A;
        repeat (3) tick();
        chk("R7 higher nests", {7'd0, int_req}, 8'h01);
        ack_expect("R7 line1", 8'h09);
        repeat (2) tick();
        wr_reg(1'b0, 8'h60);
        repeat (2) tick();
        chk("R8 other command ignored", {7'd0, int_req}, 8'h00);
        wr_reg(1'b0, 8'h20);
        repeat (2) tick();
        chk("R8 line3 still blocks", {7'd0, int_req}, 8'h00);
        wr_reg(1'b0, 8'h20);
        repeat (2) tick();
        chk("R8 held forwarded", {7'd0, int_req}, 8'h01);
        ack_expect("R8 line3 again", 8'h0B);
        wr_reg(1'b0, 8'h20);
        repeat (2) tick();
        chk("R8 next held", {7'd0, int_req}, 8'h01);
        ack_expect("R8 line5", 8'h0D);
        wr_reg(1'b0, 8'h20);
        repeat (4) tick();
        chk("R9 level no repeat", {7'd0, int_req}, 8'h00);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule